// File: doc/BRIEF.md
# Cascadable Enable-Gated Binary Decoder

This block turns a binary select value into a one-hot-low line vector. Its building block is a 3-to-8 decoder with three enable inputs of mixed polarity: one active-high and two active-low. The decoder drives an output low only when all three enables are asserted. If any enable is not asserted, every output stays high.

The top level puts two of these decoders side by side to make a 4-to-16 decoder. The most significant select bit goes to an active-low enable of the lower-half decoder and to the active-high enable of the upper-half decoder. The enables left over are either tied off or driven by a shared active-low enable, so that one input blanks all sixteen lines.

Two gate networks on the sixteen lines form Boolean functions straight from the decoder outputs. A sum-of-products function is the NAND of the lines of its minterms. A product-of-sums function is the AND of the lines of its maxterms. The term sets are parameters, so each output carries one fixed logic function of the select value.

Top module: `cascade_decoder16`

## Requirements
- R1: When all three enables of the 3-to-8 decoder are asserted, exactly one of its eight outputs is low.
- R2: The 3-to-8 decoder is enabled only with `en_hi` = 1, `en_lo_a_n` = 0 and `en_lo_b_n` = 0; with any other enable pattern all eight outputs are 1, for every select value.
- R3: When the decoder is enabled, the output that goes low is the one whose index equals the select value read as an unsigned binary number, with bit 2 as the most significant bit (select 3'b000 gives line 0, select 3'b101 gives line 5).
- R4: In the cascade, with `en_n` = 0 and `sel[3]` = 0, line `sel[2:0]` of `y_n[7:0]` is low and `y_n[15:8]` is all ones.
- R5: In the cascade, with `en_n` = 0 and `sel[3]` = 1, line 8 + `sel[2:0]` is low and `y_n[7:0]` is all ones.
- R6: With `en_n` = 1, all sixteen bits of `y_n` are 1 for every select value.
- R7: `sop_f` equals 1 exactly when `en_n` = 0 and bit `sel` of the `SOP_TERMS` parameter is 1; it equals 0 otherwise, including while the decoder is disabled. The default minterm set is {2, 4, 6}.
- R8: `pos_f` equals 0 exactly when `en_n` = 0 and bit `sel` of the `POS_TERMS` parameter is 1; it equals 1 otherwise, including while the decoder is disabled. The default maxterm set is {0, 1, 3, 5, 7}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 4 | Line select; bit 3 chooses the half, bits 2:0 choose the line within it |
| en_n | input | 1 | Shared active-low enable for both halves |
| y_n | output | 16 | One-hot-low decoded lines |
| sop_f | output | 1 | Sum-of-products function of `sel`, formed from the lines in `SOP_TERMS` |
| pos_f | output | 1 | Product-of-sums function of `sel`, formed from the lines in `POS_TERMS` |

## Verification
The bench builds the top with its default parameters: a 4-bit select, minterms {2, 4, 6} and maxterms {0, 1, 3, 5, 7}. This small build lets every select value be tried with the shared enable both on and off, which covers the half steering and the blanking of the cascade, as well as both function outputs. A second, standalone instance of the 3-bit decoder takes every select value under all eight patterns of its three enables. That sweep includes each way of missing exactly one enable and each enable polarity.

// File: rtl/dec_pkg.sv
package dec_pkg;

  typedef enum logic {
    FORM_SOP = 1'b0,
    FORM_POS = 1'b1
  } form_e;

  // True only when every enable sits at its asserting level.
  function automatic logic all_enables(input logic hi, input logic lo_a_n, input logic lo_b_n);
    return hi & ~lo_a_n & ~lo_b_n;
  endfunction

  // Level of one active-low line given the enable state and whether it is addressed.
  function automatic logic line_level(input logic enabled, input logic addressed);
    return ~(enabled & addressed);
  endfunction

endpackage

// File: rtl/dec_gated_core.sv
module dec_gated_core #(
  parameter int SEL_W = 3
) (
  input  logic                  en_hi,
  input  logic                  en_lo_a_n,
  input  logic                  en_lo_b_n,
  input  logic [SEL_W-1:0]      sel,
  output logic [(1<<SEL_W)-1:0] y_n
);
  localparam int LINES = 1 << SEL_W;

  logic enabled;
  assign enabled = dec_pkg::all_enables(en_hi, en_lo_a_n, en_lo_b_n);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic addressed;
    assign addressed = (sel == SEL_W'(i));
    assign y_n[i]    = dec_pkg::line_level(enabled, addressed);
  end

  always_comb begin
    if (enabled) begin
      p_one_low_r1: assert ($countones(~y_n) == 1)
        else $error("decoder enabled but low count is not one");
      p_index_low_r3: assert (y_n[sel] == 1'b0)
        else $error("addressed line is not the low one");
    end else begin
      p_idle_high_r2: assert (&y_n)
        else $error("decoder disabled but a line is low");
    end
  end

endmodule

// File: rtl/dec_logic_fn.sv
module dec_logic_fn #(
  parameter int                   LINES = 16,
  parameter logic [LINES-1:0]     TERMS = '0,
  parameter dec_pkg::form_e       FORM  = dec_pkg::FORM_SOP
) (
  input  logic [LINES-1:0] y_n,
  output logic             f
);
  // Lines outside the term set are forced high so they do not affect the gate.
  logic [LINES-1:0] picked_n;
  assign picked_n = y_n | ~TERMS;

  if (FORM == dec_pkg::FORM_SOP) begin : g_sop
    assign f = ~&picked_n;
    always_comb begin
      if (&y_n) begin
        p_idle_sop_r7: assert (f == 1'b0)
          else $error("sum-of-products high with no line active");
      end
    end
  end else begin : g_pos
    assign f = &picked_n;
    always_comb begin
      if (&y_n) begin
        p_idle_pos_r8: assert (f == 1'b1)
          else $error("product-of-sums low with no line active");
      end
    end
  end

endmodule

// File: rtl/cascade_decoder16.sv
module cascade_decoder16 #(
  parameter int                     SEL_W     = 4,
  parameter logic [(1<<SEL_W)-1:0]  SOP_TERMS = 'h0054,
  parameter logic [(1<<SEL_W)-1:0]  POS_TERMS = 'h00AB
) (
  input  logic [SEL_W-1:0]      sel,
  input  logic                  en_n,
  output logic [(1<<SEL_W)-1:0] y_n,
  output logic                  sop_f,
  output logic                  pos_f
);
  localparam int LOW_W = SEL_W - 1;
  localparam int HALF  = 1 << LOW_W;
  localparam int LINES = 1 << SEL_W;

  logic             half_bit;
  logic [LOW_W-1:0] low_sel;
  assign half_bit = sel[SEL_W-1];
  assign low_sel  = sel[LOW_W-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic hi_en, lo_a_n, lo_b_n;
    // Lower half: half bit on an active-low enable, active-high tied on.
    // Upper half: half bit on the active-high enable, spare active-low tied on.
    assign hi_en  = (h == 0) ? 1'b1     : half_bit;
    assign lo_a_n = (h == 0) ? half_bit : 1'b0;
    assign lo_b_n = en_n;

    dec_gated_core #(.SEL_W(LOW_W)) u_core (
      .en_hi     (hi_en),
      .en_lo_a_n (lo_a_n),
      .en_lo_b_n (lo_b_n),
      .sel       (low_sel),
      .y_n       (y_n[h*HALF +: HALF])
    );
  end

  dec_logic_fn #(.LINES(LINES), .TERMS(SOP_TERMS), .FORM(dec_pkg::FORM_SOP)) u_sop (
    .y_n (y_n),
    .f   (sop_f)
  );

  dec_logic_fn #(.LINES(LINES), .TERMS(POS_TERMS), .FORM(dec_pkg::FORM_POS)) u_pos (
    .y_n (y_n),
    .f   (pos_f)
  );

  always_comb begin
    if (!en_n && !half_bit) begin
      p_lower_half_r4: assert (&y_n[LINES-1:HALF] && !y_n[sel])
        else $error("lower half selection wrong");
    end
    if (!en_n && half_bit) begin
      p_upper_half_r5: assert (&y_n[HALF-1:0] && !y_n[sel])
        else $error("upper half selection wrong");
    end
    if (en_n) begin
      p_blank_all_r6: assert (&y_n)
        else $error("shared enable off but a line is low");
    end
  end

endmodule

// File: tb/cascade_decoder16_test.sv
module cascade_decoder16_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0]  sel;
  logic        en_n;
  logic [15:0] y_n;
  logic        sop_f, pos_f;

  cascade_decoder16 uut (
    .sel(sel), .en_n(en_n), .y_n(y_n), .sop_f(sop_f), .pos_f(pos_f)
  );

  logic       c_hi, c_a_n, c_b_n;
  logic [2:0] c_sel;
  logic [7:0] c_y_n;

  dec_gated_core #(.SEL_W(3)) core_uut (
    .en_hi(c_hi), .en_lo_a_n(c_a_n), .en_lo_b_n(c_b_n), .sel(c_sel), .y_n(c_y_n)
  );

  localparam logic [15:0] SOP_SET = 16'h0054; // minterms 2,4,6
  localparam logic [15:0] POS_SET = 16'h00AB; // maxterms 0,1,3,5,7

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    sel = '0; en_n = 1'b1;
    c_hi = 1'b0; c_a_n = 1'b1; c_b_n = 1'b1; c_sel = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Initial state: everything disabled.
    check16("R6", y_n, 16'hFFFF);
    check16("R2", {8'hFF, c_y_n}, 16'hFFFF);

    // Core sweep: all enable patterns and select values (R1, R2, R3).
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 8; s++) begin
        @(posedge clk);
        c_hi = e[0]; c_a_n = e[1]; c_b_n = e[2]; c_sel = s[2:0];
        @(negedge clk);
        if (e == 1) begin
          check16("R1", 16'($countones(~c_y_n)), 16'd1);
          check16("R3", {8'hFF, c_y_n}, {8'hFF, ~(8'd1 << s)});
        end else begin
          check16("R2", {8'hFF, c_y_n}, 16'hFFFF);
        end
      end
    end

    // Cascade sweep: shared enable on and off, all select values.
    for (int en = 0; en < 2; en++) begin
      for (int s = 0; s < 16; s++) begin
        logic [15:0] exp_y;
        logic        exp_sop, exp_pos;
        @(posedge clk);
        en_n = en[0]; sel = s[3:0];
        @(negedge clk);
        exp_y   = (en == 0) ? ~(16'd1 << s) : 16'hFFFF;
        exp_sop = (en == 0) && SOP_SET[s];
        exp_pos = !((en == 0) && POS_SET[s]);
        if (en != 0)     check16("R6", y_n, exp_y);
        else if (s < 8)  check16("R4", y_n, exp_y);
        else             check16("R5", y_n, exp_y);
        check16("R7", {15'd0, sop_f}, {15'd0, exp_sop});
        check16("R8", {15'd0, pos_f}, {15'd0, exp_pos});
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule